// File: doc/BRIEF.md
# Burst-of-Four Dual-Port SRAM Sequencer

This block models a synchronous static RAM whose read data and write data use separate ports and whose every access moves four words. Commands arrive as two active-low strobes and one shared address. The block samples them only on rising edges of the main command clock K. An accepted command always covers four consecutive locations, starting at the given base address and wrapping at the top of the address space.

The block runs from a single clock `clk` at twice the K rate, so one tick is half a K period. A phase register set by reset marks which `clk` edges are K rising edges, and `k_edge_next` brings that phase out. Write words are taken from `din` on four successive ticks, starting one K period after the command. Read words appear on `dout` on four successive ticks, starting two and a half K periods after the command. Read and write bursts have independent pipelines, so they may overlap.

Two rules limit acceptance. A strobe that was honoured on one K edge is refused on the next K edge. If both strobes are low on a K edge that follows a K edge with nothing accepted, the read is taken and the write is dropped. The `idle` flag tells the surrounding logic when it is safe to stop the clock.

Top module: `qdr_burst_sram`

## Requirements
- R1: An accepted command covers addresses base, base+1, base+2 and base+3, each taken modulo 2^AW (base 14 with AW=4 gives 14, 15, 0, 1).
- R2: After reset the first `clk` edge is a K edge and K edges then fall on every second `clk` edge. `k_edge_next` is high during exactly those ticks whose closing edge is a K edge. `rd_n`, `wr_n` and `addr` have no effect on any other edge.
- R3: For a write accepted on edge t, `din` is stored at edges t+2, t+3, t+4 and t+5 into base+0 through base+3, in that order.
- R4: For a read accepted on edge t, `dout` shows base+0 through base+3 after edges t+5, t+6, t+7 and t+8. `dout_oe` is high from edge t+5 until edge t+9, unless the next read burst follows straight on.
- R5: A read strobe on the K edge right after a K edge that accepted a read is ignored. A write strobe on the K edge right after a K edge that accepted a write is ignored. On the K edge after that, the strobe is honoured again.
- R6: When both strobes are low on a K edge and the previous K edge accepted nothing, only the read is accepted and memory is left unchanged. When the previous K edge accepted a read, only the write is accepted.
- R7: Whenever `dout_oe` is low, `dout` is all zeros. After reset, `dout_oe` is low.
- R8: `idle` goes low after the edge that accepts a command. It stays low until the edge that stores the last write word or drives the last read word of every accepted burst. It is high after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at twice the K rate, aligned to K rising edges |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_n | input | 1 | Read strobe, active low, sampled on K edges |
| wr_n | input | 1 | Write strobe, active low, sampled on K edges |
| addr | input | AW | Burst base address, sampled on K edges |
| din | input | DW | Write data, one word per tick during a write burst |
| dout | output | DW | Read data, one word per tick during a read burst |
| dout_oe | output | 1 | High while `dout` carries a read word (low means high-impedance) |
| idle | output | 1 | High when no accepted burst is outstanding |
| k_edge_next | output | 1 | High during a tick whose closing `clk` edge is a K rising edge |

## Verification
The assertions assume that `clk` runs at twice the K rate and that nothing but reset sets its phase. They also assume that the strobes matter only on K edges, and that a read and a write in flight together never touch the same word on the same tick. The bench drives inputs only at falling `clk` edges. It lines every command up on a tick where `k_edge_next` is high, and it gives overlapping reads and writes disjoint address ranges. It pre-loads every region it later reads, so that each expected word comes from a reference array and never from an unwritten location.

// File: rtl/qb_pkg.sv
// Shared constants and types for the burst SRAM sequencer.
// Assumes timing is counted in ticks of a clock at twice the K rate.
package qb_pkg;
    localparam int BURST_LEN    = 4;   // words per command
    localparam int RD_LAT_TICKS = 5;   // command edge to first read word
    localparam int WR_LAT_TICKS = 2;   // command edge to first write capture

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RD   = 2'd1,
        CMD_WR   = 2'd2
    } cmd_e;
endpackage

// File: rtl/qb_cmd_gate.sv
// Command gate: tracks the K phase inside the 2x tick clock and decides
// which strobes are honoured on each K edge (alternate-edge rule and
// read-wins-after-idle rule). Assumes reset aligns the phase to K.
module qb_cmd_gate
    import qb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_n,
    input  logic wr_n,
    output logic k_edge,
    output logic rd_acc,
    output logic wr_acc
);
    logic phase;
    cmd_e last_cmd;

    assign k_edge = ~phase;

    // Acceptance decision for the current edge.
    always_comb begin
        rd_acc = k_edge && !rd_n && (last_cmd != CMD_RD);
        wr_acc = k_edge && !wr_n && (last_cmd != CMD_WR)
                 && !((last_cmd == CMD_NONE) && !rd_n);
    end

    // Half-period phase: low during ticks that close on a K edge.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // Remember what the latest K edge accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_cmd <= CMD_NONE;
        else if (k_edge)
            last_cmd <= rd_acc ? CMD_RD : (wr_acc ? CMD_WR : CMD_NONE);
    end

    // R2: commands are only taken on K edges
    a_r2_accept_on_kedge: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc || wr_acc) |-> k_edge);

    // R5: no read on the K edge after an accepted read
    a_r5_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> !rd_acc ##1 !rd_acc);

    // R5: no write on the K edge after an accepted write
    a_r5_wr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> !wr_acc ##1 !wr_acc);

    // R6: a single edge never takes both a read and a write
    a_r6_one_per_edge: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |-> !wr_acc);
endmodule

// File: rtl/qb_burst_seq.sv
// Burst sequencer: delays an accepted command by LAT ticks, then issues
// four beats on consecutive ticks at consecutive addresses. Assumes
// pushes are at least BURST_LEN ticks apart (the K alternate-edge rule).
module qb_burst_seq
    import qb_pkg::*;
#(
    parameter int AW  = 4,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    output logic          fire,
    output logic [AW-1:0] beat_addr,
    output logic          busy
);
    localparam int CW = $clog2(BURST_LEN);
    localparam logic [CW-1:0] LAST_REM = CW'(BURST_LEN - 1);

    logic [LAT-1:0] pv;
    logic [AW-1:0]  pa [LAT];
    logic [CW-1:0]  rem;
    logic [AW-1:0]  cur;
    logic           start;

    // Beat issue and address selection.
    always_comb begin
        start     = pv[LAT-1];
        fire      = start || (rem != '0);
        beat_addr = start ? pa[LAT-1] : cur;
        busy      = (|pv) || (rem != '0);
    end

    // Latency pipe: valid bits shift once per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= '0;
        else        pv <= {pv[LAT-2:0], push};
    end

    // Latency pipe: first address stage.
    always_ff @(posedge clk) begin
        if (!rst_n) pa[0] <= '0;
        else        pa[0] <= push_addr;
    end

    for (genvar i = 1; i < LAT; i++) begin : g_stage
        // Latency pipe: later address stages.
        always_ff @(posedge clk) begin
            if (!rst_n) pa[i] <= '0;
            else        pa[i] <= pa[i-1];
        end
    end

    // Beat counter and address stepping inside a burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem <= '0;
            cur <= '0;
        end else if (start) begin
            rem <= LAST_REM;
            cur <= pa[LAT-1] + AW'(1);
        end else if (rem != '0) begin
            rem <= rem - CW'(1);
            cur <= cur + AW'(1);
        end
    end

    // R1: a burst issues four consecutive beats
    a_r1_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> fire ##1 fire ##1 fire);

    // R1: the second beat addresses the word after the base
    a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (beat_addr == $past(beat_addr) + AW'(1)));
endmodule

// File: rtl/qb_store.sv
// Storage array with one write port and one registered read port.
// The read register holds zero whenever no read word is being driven.
// Assumes a write and a read never target the same word on one tick.
module qb_store #(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata_q,
    output logic          rvalid_q
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Array write, one word per tick.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read output register with enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n || !re) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rdata_q  <= mem[raddr];
            rvalid_q <= 1'b1;
        end
    end

    // R4: once driving starts, four words follow
    a_r4_oe_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid_q) |=> rvalid_q ##1 rvalid_q ##1 rvalid_q);
endmodule

// File: rtl/qdr_burst_sram.sv
// Top: burst-of-four SRAM with separate read and write data ports.
// Runs on a 2x tick clock; reset aligns the internal K phase so that
// the first edge after reset is a K rising edge.
module qdr_burst_sram
    import qb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          dout_oe,
    output logic          idle,
    output logic          k_edge_next
);
    logic          k_edge;
    logic          rd_acc;
    logic          wr_acc;
    logic          rd_fire;
    logic          wr_fire;
    logic [AW-1:0] rd_addr;
    logic [AW-1:0] wr_addr;
    logic          rd_busy;
    logic          wr_busy;

    qb_cmd_gate u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .k_edge (k_edge),
        .rd_acc (rd_acc),
        .wr_acc (wr_acc)
    );

    qb_burst_seq #(.AW(AW), .LAT(RD_LAT_TICKS)) u_rd_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_acc),
        .push_addr (addr),
        .fire      (rd_fire),
        .beat_addr (rd_addr),
        .busy      (rd_busy)
    );

    qb_burst_seq #(.AW(AW), .LAT(WR_LAT_TICKS)) u_wr_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_acc),
        .push_addr (addr),
        .fire      (wr_fire),
        .beat_addr (wr_addr),
        .busy      (wr_busy)
    );

    qb_store #(.AW(AW), .DW(DW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_fire),
        .waddr    (wr_addr),
        .wdata    (din),
        .re       (rd_fire),
        .raddr    (rd_addr),
        .rdata_q  (dout),
        .rvalid_q (dout_oe)
    );

    // Outward flags.
    assign idle        = !rd_busy && !wr_busy;
    assign k_edge_next = k_edge;

    // R8: idle only drops on the edge after a command is accepted
    a_r8_idle_falls: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(idle) |-> $past(rd_acc || wr_acc));
endmodule

// File: tb/qdr_burst_sram_tb.sv
module qdr_burst_sram_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam logic [DW-1:0] JUNK = 16'hBAD0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_n = 1'b1;
    logic          wr_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;
    logic          idle;
    logic          k_edge_next;

    logic [DW-1:0] ref_mem [16];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    qdr_burst_sram #(.AW(AW), .DW(DW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .addr        (addr),
        .din         (din),
        .dout        (dout),
        .dout_oe     (dout_oe),
        .idle        (idle),
        .k_edge_next (k_edge_next)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic align();
        while (!k_edge_next) step();
    endtask

    // R3/R8: one write burst; edge k counted from the command edge
    task automatic do_write(input logic [AW-1:0] base, input logic [DW-1:0] seed);
        align();
        for (int k = 0; k < 6; k++) begin
            wr_n = (k == 0) ? 1'b0 : 1'b1;
            addr = base;
            din  = (k >= 2) ? seed + DW'(k - 2) : JUNK;
            step();
            if (k == 0) check("R8", "idle after write command", idle, 0);
            if (k == 4) check("R8", "idle before last write word", idle, 0);
            if (k == 5) check("R8", "idle after last write word", idle, 1);
        end
        for (int i = 0; i < 4; i++) ref_mem[4'(base + i)] = seed + DW'(i);
    endtask

    // R1/R4/R7/R8: one read burst with per-tick checks
    task automatic do_read(input logic [AW-1:0] base);
        align();
        for (int k = 0; k < 10; k++) begin
            rd_n = (k == 0) ? 1'b0 : 1'b1;
            addr = base;
            step();
            if (k == 4) check("R4", "oe before first read word", dout_oe, 0);
            if (k >= 5 && k <= 8) begin
                check("R4", "oe during read burst", dout_oe, 1);
                check("R1", "read word", dout, ref_mem[4'(base + (k - 5))]);
            end
            if (k == 7) check("R8", "idle before last read word", idle, 0);
            if (k == 8) check("R8", "idle after last read word", idle, 1);
            if (k == 9) begin
                check("R4", "oe after read burst", dout_oe, 0);
                check("R7", "dout quiet", dout, 0);
            end
        end
    endtask

    task automatic t_reset();
        check("R7", "oe after reset", dout_oe, 0);
        check("R7", "dout after reset", dout, 0);
        check("R8", "idle after reset", idle, 1);
        check("R2", "first edge is K", k_edge_next, 1);
        step();
        check("R2", "second edge not K", k_edge_next, 0);
        step();
        check("R2", "third edge is K", k_edge_next, 1);
    endtask

    task automatic t_basic();
        do_write(4'd4, 16'h1100);
        do_write(4'd0, 16'h2200);
        do_write(4'd8, 16'h3300);
        do_write(4'd12, 16'h4400);
        do_read(4'd4);
        do_read(4'd0);
    endtask

    // R1: burst wraps at the top of the address space
    task automatic t_wrap();
        do_write(4'd14, 16'h5500);
        do_read(4'd14);
        do_read(4'd12);
    endtask

    // R5: read strobe held over three K edges with three addresses
    task automatic t_rd_b2b();
        align();
        for (int k = 0; k < 14; k++) begin
            rd_n = (k <= 4) ? 1'b0 : 1'b1;
            addr = (k < 2) ? 4'd0 : ((k < 4) ? 4'd8 : 4'd4);
            step();
            if (k >= 5 && k <= 8)
                check("R5", "first read word", dout, ref_mem[4'(k - 5)]);
            if (k >= 9 && k <= 12) begin
                check("R5", "third-edge read word", dout, ref_mem[4'(4 + k - 9)]);
                check("R5", "oe continuous", dout_oe, 1);
            end
            if (k == 12) check("R8", "idle after back-to-back reads", idle, 1);
            if (k == 13) check("R5", "second read dropped", dout_oe, 0);
        end
    endtask

    // R5: second write on the next K edge leaves its target untouched
    task automatic t_wr_b2b();
        align();
        for (int k = 0; k < 10; k++) begin
            wr_n = (k == 0 || k == 2) ? 1'b0 : 1'b1;
            addr = (k < 2) ? 4'd12 : 4'd8;
            din  = (k >= 2 && k <= 5) ? 16'h6600 + DW'(k - 2) : JUNK + DW'(k);
            step();
            if (k == 5) check("R5", "idle with second write dropped", idle, 1);
        end
        for (int i = 0; i < 4; i++) ref_mem[4'(12 + i)] = 16'h6600 + DW'(i);
        do_read(4'd8);
        do_read(4'd12);
    endtask

    // R6: both strobes after an idle K edge: read only
    task automatic t_both_after_nop();
        align();
        step();
        step();
        for (int k = 0; k < 10; k++) begin
            rd_n = (k == 0) ? 1'b0 : 1'b1;
            wr_n = (k == 0) ? 1'b0 : 1'b1;
            addr = 4'd8;
            din  = JUNK + DW'(k);
            step();
            if (k >= 5 && k <= 8)
                check("R6", "read taken, write dropped", dout, ref_mem[4'(8 + k - 5)]);
            if (k == 8) check("R6", "oe on last word", dout_oe, 1);
        end
        do_read(4'd8);
    endtask

    // R6: both strobes after an accepted read: write only, overlapping
    task automatic t_both_after_read();
        align();
        for (int k = 0; k < 10; k++) begin
            rd_n = (k == 0 || k == 2) ? 1'b0 : 1'b1;
            wr_n = (k == 2) ? 1'b0 : 1'b1;
            addr = (k < 2) ? 4'd0 : 4'd12;
            din  = (k >= 4 && k <= 7) ? 16'h7700 + DW'(k - 4) : JUNK;
            step();
            if (k >= 5 && k <= 8)
                check("R6", "read beside write", dout, ref_mem[4'(k - 5)]);
            if (k == 7) check("R8", "idle with read pending", idle, 0);
            if (k == 8) check("R8", "idle after overlap", idle, 1);
            if (k == 9) check("R6", "second read dropped", dout_oe, 0);
        end
        for (int i = 0; i < 4; i++) ref_mem[4'(12 + i)] = 16'h7700 + DW'(i);
        do_read(4'd12);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_wrap();
        t_rd_b2b();
        t_wr_b2b();
        t_both_after_nop();
        t_both_after_read();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule